// File: doc/BRIEF.md
# Stoppable PCI Clock Generator

This block turns a fast reference clock into a set of PCI-rate clocks by integer division. One output always runs. The other outputs can be stopped and restarted by an active-low request, and that request may change at any time with no relation to the reference clock. Every output is the output of a register clocked by the reference, and gating decisions take effect only at PCI period boundaries. As a result a stopped output always rests low, and the first pulse after a restart always has its full high time.

The request passes through a synchronizer. The enable is then evaluated once per PCI period, at the last reference cycle of the high phase. A released request has to be seen for a fixed number of consecutive periods before the gated clocks restart. After a restart the gated clocks stay on for a minimum number of periods, even if a stop is requested during that time. A stop request that is still asserted when this window closes takes effect at that boundary. The block is meant to sit beside a power-management controller that drives the request.

Top module: `pci_clock_gater`

## Requirements
- R1: While `rst_n` is low, `pci_free` and every bit of `pci_gated` are low. Reset leaves the gated clocks running, and the minimum-on window starts counting at the first period after reset.
- R2: `pci_free` repeats every `DIV` reference cycles. In each period it is low for the first `DIV/2` cycles and high for the remaining `DIV/2` cycles. The stop request has no effect on it.
- R3: In any PCI period, each gated output is either low for the whole period or an exact copy of `pci_free` for that period. All gated outputs are identical at every cycle.
- R4: Once stopped, the gated outputs stay low for as long as `stop_req_n` is held low.
- R5: `stop_req_n` is low (stop) and high (run). It passes a `SYNC_STAGES`-deep synchronizer. When a stop is seen at the end of period p and the minimum-on window has closed, period p still carries a gated pulse and period p+1 does not.
- R6: When a release is first seen at the end of period q, the first gated pulse appears in period q+`ON_LAT`. This is the `ON_LAT`-th rising edge of `pci_free` after that boundary.
- R7: After a restart, the gated clocks carry at least `MIN_ON` consecutive pulses. A stop seen during that window is applied at the first boundary where the window has closed, provided it is still asserted there.
- R8: A release that lasts fewer than `ON_LAT` periods produces no gated pulse. The wake count starts over from zero on the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock; all outputs are registered on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous stop request: 0 stops the gated clocks, 1 lets them run |
| pci_free | output | 1 | Free-running divided PCI clock |
| pci_gated | output | N_OUT | Stoppable divided PCI clocks |

## Verification
A phase counter that skips or repeats a value changes the high time of `pci_free` within one PCI period. A gated output that leaves its enable mid-phase shows up in that same period as a pulse shorter than the free clock's. An off-by-one in the wake counter or the window counter moves the first or last gated pulse by a whole PCI period. Sweeping the release length from one period to well past the window makes such a shift change the pulse count of at least one scenario. A wake counter that fails to clear on an aborted release produces stray pulses when the request toggles every period.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [0:0] {
    ST_RUN    = 1'b0,
    ST_PARKED = 1'b1
  } gate_state_t;

  // Phase index following ph in a divide-by-div cycle.
  function automatic int unsigned step_phase(int unsigned ph, int unsigned div);
    return (ph == div - 1) ? 0 : ph + 1;
  endfunction

  // The upper half of the phase range is the high phase.
  function automatic logic phase_is_high(int unsigned ph, int unsigned div);
    return ph >= (div / 2);
  endfunction

  // True when one more counted period completes a span of `need` periods.
  function automatic logic span_reached(int unsigned count, int unsigned need);
    return (count + 1) >= need;
  endfunction

endpackage

// File: rtl/pcs_divider.sv
module pcs_divider #(
  parameter int unsigned DIV = 4,
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic free_clk,
  output logic high_next,
  output logic period_end
);
  logic [PW-1:0] phase;
  logic [PW-1:0] phase_nxt;

  always_comb begin
    phase_nxt  = PW'(pcs_pkg::step_phase(32'(phase), DIV));
    high_next  = pcs_pkg::phase_is_high(32'(phase_nxt), DIV);
    period_end = (32'(phase) == DIV - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= '0;
      free_clk <= 1'b0;
    end else begin
      phase    <= phase_nxt;
      free_clk <= high_next;
    end
  end
endmodule

// File: rtl/pcs_sync.sv
module pcs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pcs_gate_ctrl.sv
module pcs_gate_ctrl #(
  parameter int unsigned ON_LAT = 3,
  parameter int unsigned MIN_ON = 10,
  localparam int unsigned WW = $clog2(ON_LAT + 1),
  localparam int unsigned MW = $clog2(MIN_ON + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run_req,
  output logic gate_en
);
  import pcs_pkg::*;

  gate_state_t    state;
  logic [WW-1:0]  wake_cnt;
  logic [MW-1:0]  win_cnt;
  logic           win_done;
  logic           wake_done;

  always_comb begin
    win_done  = span_reached(32'(win_cnt), MIN_ON);
    wake_done = span_reached(32'(wake_cnt), ON_LAT);
    gate_en   = (state == ST_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RUN;
      wake_cnt <= '0;
      win_cnt  <= '0;
    end else if (tick) begin
      unique case (state)
        ST_RUN: begin
          if (!run_req && win_done) begin
            state    <= ST_PARKED;
            wake_cnt <= '0;
          end else if (!win_done) begin
            win_cnt <= win_cnt + 1'b1;
          end
        end
        ST_PARKED: begin
          if (!run_req) begin
            wake_cnt <= '0;
          end else if (wake_done) begin
            state    <= ST_RUN;
            wake_cnt <= '0;
            win_cnt  <= '0;
          end else begin
            wake_cnt <= wake_cnt + 1'b1;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/pcs_out_gate.sv
module pcs_out_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic high_next,
  output logic clk_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_out <= 1'b0;
    else        clk_out <= enable & high_next;
  end
endmodule

// File: rtl/pci_clock_gater.sv
module pci_clock_gater #(
  parameter int unsigned DIV         = 4,
  parameter int unsigned N_OUT       = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ON_LAT      = 3,
  parameter int unsigned MIN_ON      = 10
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             stop_req_n,
  output logic             pci_free,
  output logic [N_OUT-1:0] pci_gated
);
  // Named internal events, also observed by the bound checker.
  logic period_end;
  logic high_next;
  logic run_req;
  logic gate_en;

  pcs_divider #(.DIV(DIV)) u_div (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .free_clk   (pci_free),
    .high_next  (high_next),
    .period_end (period_end)
  );

  pcs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .d     (stop_req_n),
    .q     (run_req)
  );

  pcs_gate_ctrl #(.ON_LAT(ON_LAT), .MIN_ON(MIN_ON)) u_ctrl (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .tick    (period_end),
    .run_req (run_req),
    .gate_en (gate_en)
  );

  for (genvar gi = 0; gi < N_OUT; gi++) begin : g_out
    pcs_out_gate u_gate (
      .clk       (clk_ref),
      .rst_n     (rst_n),
      .enable    (gate_en),
      .high_next (high_next),
      .clk_out   (pci_gated[gi])
    );
  end
endmodule

// File: rtl/pci_clock_gater_chk.sv
module pci_clock_gater_chk #(
  parameter int unsigned DIV    = 4,
  parameter int unsigned N_OUT  = 2,
  parameter int unsigned MIN_ON = 10,
  localparam int unsigned HALF  = DIV / 2,
  localparam int unsigned HW    = $clog2(DIV + 1),
  localparam int unsigned EW    = $clog2(MIN_ON + 1) + 1
) (
  input logic             clk_ref,
  input logic             rst_n,
  input logic             pci_free,
  input logic [N_OUT-1:0] pci_gated,
  input logic             gate_en,
  input logic             period_end
);
  logic [HW-1:0] hi_cnt;
  logic [EW-1:0] en_ticks;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt   <= '0;
      en_ticks <= '0;
    end else begin
      hi_cnt <= pci_free ? hi_cnt + 1'b1 : '0;
      if (!gate_en && period_end)
        en_ticks <= '0;
      else if (gate_en && period_end && (32'(en_ticks) < MIN_ON))
        en_ticks <= en_ticks + 1'b1;
    end
  end

  AST_FREE_HIGH_WIDTH: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(pci_free) |-> (32'(hi_cnt) == HALF)); // R2

  AST_GATED_RISE_ALIGNED: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(pci_gated[0]) |-> $rose(pci_free)); // R3

  AST_GATED_FALL_ALIGNED: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(pci_gated[0]) |-> $fell(pci_free)); // R3

  AST_GATED_ALL_EQUAL: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (pci_gated == '0) || (pci_gated == '1)); // R3

  AST_ENABLE_AT_BOUNDARY: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $changed(gate_en) |-> $past(period_end)); // R3

  AST_PARKED_LOW: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !gate_en |-> (pci_gated == '0)); // R4

  AST_MIN_ENABLE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(gate_en) |-> (32'(en_ticks) >= MIN_ON)); // R7
endmodule

bind pci_clock_gater pci_clock_gater_chk #(
  .DIV(DIV), .N_OUT(N_OUT), .MIN_ON(MIN_ON)
) u_chk (
  .clk_ref    (clk_ref),
  .rst_n      (rst_n),
  .pci_free   (pci_free),
  .pci_gated  (pci_gated),
  .gate_en    (gate_en),
  .period_end (period_end)
);

// File: tb/test_pci_clock_gater.sv
module test_pci_clock_gater;
  localparam int DIV    = 4;
  localparam int HALF   = DIV / 2;
  localparam int N_OUT  = 2;
  localparam int ON_LAT = 3;
  localparam int MIN_ON = 10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             stop_n;
  logic             pci_free;
  logic [N_OUT-1:0] pci_gated;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  pci_clock_gater #(
    .DIV(DIV), .N_OUT(N_OUT), .SYNC_STAGES(2), .ON_LAT(ON_LAT), .MIN_ON(MIN_ON)
  ) i_pci_clock_gater (
    .clk_ref    (clk),
    .rst_n      (rst_n),
    .stop_req_n (stop_n),
    .pci_free   (pci_free),
    .pci_gated  (pci_gated)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Runs one PCI period starting at the negedge of its first (low) reference cycle.
  task automatic run_period(input logic lvl, output int g_hi, output int f_hi, output int bad);
    stop_n = lvl;
    g_hi = 0; f_hi = 0; bad = 0;
    for (int k = 0; k < DIV; k++) begin
      if (pci_free) f_hi++;
      if (pci_gated[0]) g_hi++;
      if (pci_free != (k >= HALF)) bad++;
      if (pci_gated != {N_OUT{pci_gated[0]}}) bad++;
      if (pci_gated[0] && !pci_free) bad++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  initial begin
    int gh, fh, bd;
    int f_bad, g_bad, shape_bad;
    rst_n  = 1'b0;
    stop_n = 1'b1;

    // R1: outputs low during reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(pci_free == 1'b0 && pci_gated == '0, "R1 reset outputs low",
            int'({pci_free, pci_gated}), 0);
    end
    rst_n = 1'b1;

    // R2/R3: running after reset, twelve periods
    f_bad = 0; g_bad = 0;
    for (int p = 0; p < 12; p++) begin
      run_period(1'b1, gh, fh, bd);
      if (fh != HALF || bd != 0) f_bad++;
      if (gh != HALF) g_bad++;
    end
    check(f_bad == 0, "R2 free clock shape after reset", f_bad, 0);
    check(g_bad == 0, "R3 gated copies free after reset", g_bad, 0);

    // R5: window has closed; stop seen at end of this period
    run_period(1'b0, gh, fh, bd);
    check(gh == HALF, "R5 pulse kept in request period", gh, HALF);
    run_period(1'b0, gh, fh, bd);
    check(gh == 0, "R5 no pulse one period later", gh, 0);

    // R4/R2: held stopped
    g_bad = 0; f_bad = 0;
    for (int p = 0; p < 20; p++) begin
      run_period(1'b0, gh, fh, bd);
      g_bad += gh;
      if (fh != HALF || bd != 0) f_bad++;
    end
    check(g_bad == 0, "R4 parked low while stopped", g_bad, 0);
    check(f_bad == 0, "R2 free clock unaffected by stop", f_bad, 0);

    // R6/R7/R8: sweep release length d
    for (int d = 1; d <= 16; d++) begin
      int total, first, exp_cnt;
      total = 0; first = -1; shape_bad = 0;
      for (int p = 0; p < d + 30; p++) begin
        run_period((p < d) ? 1'b1 : 1'b0, gh, fh, bd);
        if (gh != 0 && gh != HALF) shape_bad++;
        if (bd != 0 || fh != HALF) shape_bad++;
        if (gh == HALF) begin
          total++;
          if (first < 0) first = p;
        end
      end
      check(shape_bad == 0, "R3 full-or-absent pulses in sweep", shape_bad, 0);
      if (d < ON_LAT) begin
        check(total == 0, "R8 short release gives no pulse", total, 0);
      end else begin
        exp_cnt = (d - (ON_LAT - 1) > MIN_ON) ? d - (ON_LAT - 1) : MIN_ON;
        check(first == ON_LAT, "R6 restart latency", first, ON_LAT);
        check(total == exp_cnt, "R7 enabled pulse count", total, exp_cnt);
      end
    end

    // R8: toggling every period never completes the wake count
    g_bad = 0;
    for (int p = 0; p < 24; p++) begin
      run_period(p[0] ? 1'b0 : 1'b1, gh, fh, bd);
      g_bad += gh;
    end
    check(g_bad == 0, "R8 alternating request gives no pulse", g_bad, 0);

    // R8: wake count restarted, so a full release after toggling restarts on time
    begin
      int first;
      first = -1;
      for (int p = 0; p < 8; p++) begin
        run_period(1'b1, gh, fh, bd);
        if (gh == HALF && first < 0) first = p;
      end
      check(first == ON_LAT, "R8 wake count restarts after abort", first, ON_LAT);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule